// File: doc/BRIEF.md
# Tamper Response Sequencer

This block watches a set of tamper-detect lines and, once any of them fires, drives the chip's penalty controls in one fixed order. First it disables all outputs. Then it pulses the global register reset. Next it sends a two-word status record to the system over a valid/ready stream. It then drives the active-low key-erase line low. Last, it raises a reprogram command toward the internal configuration port. Each step is held for at least `HOLD_CYC` cycles before the next step starts. After the final step the block parks in a terminal state, and only a block reset brings it out.

The block also sits in the path of the external reprogram request. In normal mode a request starts a memory scrub through a start/busy/done handshake, because the global register reset does not reach shift-register or block memories. The acknowledge rises only once the scrub reports that it has finished. If the hostile-request mode input is high, a request is treated as an attack instead: the full penalty sequence runs first, and the acknowledge is given only after it. Sequencer states are coded so that any two legal codes differ in at least three bits, and an illegal code falls into the penalty path.

Top module: `tamper_response_seq`

## Requirements
- R1: While reset is active, and after it is released, `out_disable`=0, `reg_reset`=0, `key_erase_n`=1, `cfg_cmd_valid`=0, `reprog_ack`=0, `scrub_start`=0 and `status_valid`=0.
- R2: A tamper line held high makes `out_disable` rise before any other penalty output changes, and `reg_reset` is only ever high while `out_disable` is high.
- R3: Each penalty step lasts exactly `HOLD_CYC` cycles, except the status step, which also waits for the record. `out_disable` is high alone for `HOLD_CYC` cycles, then `reg_reset` is high for `HOLD_CYC` cycles, then `key_erase_n` is low for `HOLD_CYC` cycles, then `cfg_cmd_valid` is high for `HOLD_CYC` cycles.
- R4: After `reg_reset` ends, the block sends two words on `status_data` with valid/ready. Word 0 bits [1:0] hold the cause code (01 = tamper line, 10 = hostile reprogram request, 11 = illegal state) and its other bits are zero. Word 1 holds, in its low `NUM_SRC` bits, the tamper lines captured at penalty entry. `status_last` marks word 1, and `status_data` holds steady while `status_valid` is high and `status_ready` is low.
- R5: `key_erase_n` goes low only after the last status word has been accepted, and never on the benign request path.
- R6: `cfg_cmd_valid` rises in the cycle right after the key-erase step ends.
- R7: In normal mode a request gives a one-cycle `scrub_start` pulse. `reprog_ack` rises only after `scrub_done` is seen with `scrub_busy` low, stays high while the request is held, and drops after the request falls, leaving the block ready to serve another request.
- R8: In hostile mode a request runs the penalty sequence with cause 10 and no scrub. `reprog_ack` is raised only after the reprogram command step has ended.
- R9: A tamper line that fires while a scrub is outstanding pre-empts the handshake: the penalty runs with cause 01 and no acknowledge is given before the sequence ends.
- R10: Once the sequence has finished, `out_disable` stays high and the other penalty outputs stay inactive, whatever the inputs do, until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tamper_in | input | NUM_SRC | Tamper-detect lines, active high, asynchronous |
| req_hostile_mode | input | 1 | 1 = treat any reprogram request as an attack |
| reprog_req | input | 1 | External reprogram request, held high until acknowledged |
| reprog_ack | output | 1 | Acknowledge that releases the held-off reprogram |
| scrub_start | output | 1 | One-cycle pulse that starts the memory scrub |
| scrub_busy | input | 1 | Scrub engine is working |
| scrub_done | input | 1 | Scrub engine has finished |
| out_disable | output | 1 | Global output disable (all pins high impedance) |
| reg_reset | output | 1 | Global register reset |
| status_valid | output | 1 | Status word valid |
| status_ready | input | 1 | System accepts the status word |
| status_data | output | DATA_W | Status word |
| status_last | output | 1 | Marks the final status word |
| key_erase_n | output | 1 | Key erase, active low |
| cfg_cmd_valid | output | 1 | Reprogram command to the internal configuration port |

## Verification
The hardest situation to reach from the ports is a tamper event that arrives while a benign scrub is still outstanding, with the request held high and no done reported. The bench gets there by raising a normal-mode request, waiting for the scrub start pulse, and holding `scrub_done` low while it raises a tamper line. It then checks that the acknowledge stays low through the whole penalty and only follows the request in the terminal state. Ordering is checked by a monitor that logs the first and last cycle of every penalty output. The monitor also stalls `status_ready` so that the status step must wait and the data must hold still.

// File: rtl/tamper_seq_pkg.sv
package tamper_seq_pkg;

  // Sequencer state codes: any two codes differ in at least three bits.
  typedef enum logic [7:0] {
    ST_IDLE       = 8'h1D,
    ST_SCRUB_GO   = 8'h2B,
    ST_SCRUB_WAIT = 8'h36,
    ST_ACK        = 8'h47,
    ST_P_OFF      = 8'h5A,
    ST_P_RST      = 8'h6C,
    ST_P_STAT     = 8'h71,
    ST_P_KEY      = 8'h8E,
    ST_P_PROG     = 8'h93,
    ST_HALT       = 8'hA5
  } seq_state_e;

  localparam logic [1:0] CAUSE_NONE     = 2'b00;
  localparam logic [1:0] CAUSE_TAMPER   = 2'b01;
  localparam logic [1:0] CAUSE_HOSTILE  = 2'b10;
  localparam logic [1:0] CAUSE_BADSTATE = 2'b11;

  localparam int STATUS_WORDS = 2;

endpackage

// File: rtl/tamper_detect.sv
module tamper_detect #(
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tamper_in,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               any_o
);

  logic [NUM_SRC-1:0] synced;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;
  logic               mask_en;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], tamper_in[g]};
    end
    assign synced[g] = sh_q[SYNC_STAGES-1];
  end

  always_comb begin
    mask_en = |synced;
    mask_d  = mask_q | synced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign any_o  = |mask_q;

  // Latched sources are never lost before reset.
  assert_mask_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |=> any_o);

endmodule

// File: rtl/tamper_step_timer.sv
module tamper_step_timer #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int            CW       = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // A step entry restarts the full hold window.
  assert_reload_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && HOLD_CYC > 1) |=> !expired);

endmodule

// File: rtl/tamper_status_tx.sv
module tamper_status_tx
  import tamper_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [1:0]         cause,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               ready,
  output logic               valid,
  output logic [DATA_W-1:0]  data,
  output logic               last,
  output logic               done
);

  localparam int            IW       = (STATUS_WORDS > 2) ? $clog2(STATUS_WORDS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(STATUS_WORDS - 1);

  logic          valid_q, valid_d;
  logic          done_q,  done_d;
  logic [IW-1:0] idx_q,   idx_d;

  always_comb begin
    valid_d = valid_q;
    done_d  = done_q;
    idx_d   = idx_q;
    if (!valid_q) begin
      if (go && !done_q) begin
        valid_d = 1'b1;
        idx_d   = '0;
      end
    end else if (ready) begin
      if (idx_q == LAST_IDX) begin
        valid_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      done_q  <= done_d;
      idx_q   <= idx_d;
    end
  end

  always_comb begin
    data = '0;
    if (idx_q == '0) data[1:0]         = cause;
    else             data[NUM_SRC-1:0] = mask;
  end

  assign valid = valid_q;
  assign last  = valid_q && (idx_q == LAST_IDX);
  assign done  = done_q;

  assert_word_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data)));

  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && !valid));

endmodule

// File: rtl/tamper_response_seq.sv
module tamper_response_seq
  import tamper_seq_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int DATA_W      = 8,
  parameter int HOLD_CYC    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] tamper_in,
  input  logic               req_hostile_mode,
  input  logic               reprog_req,
  output logic               reprog_ack,
  output logic               scrub_start,
  input  logic               scrub_busy,
  input  logic               scrub_done,
  output logic               out_disable,
  output logic               reg_reset,
  output logic               status_valid,
  input  logic               status_ready,
  output logic [DATA_W-1:0]  status_data,
  output logic               status_last,
  output logic               key_erase_n,
  output logic               cfg_cmd_valid
);

  // Reset: asserted at once, released two clocks later.
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // Detection.
  logic [NUM_SRC-1:0] src_mask;
  logic               tamper_any;

  tamper_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk       (clk),
    .rst_n     (arst_n),
    .tamper_in (tamper_in),
    .mask_o    (src_mask),
    .any_o     (tamper_any)
  );

  // Sequencer.
  seq_state_e         state_q, state_d;
  logic [1:0]         cause_q, cause_d;
  logic [NUM_SRC-1:0] snap_q;
  logic               pen_enter;
  logic               step_load;
  logic               step_done;
  logic               tx_done;

  always_comb begin
    state_d   = state_q;
    cause_d   = cause_q;
    pen_enter = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tamper_any) begin
          state_d = ST_P_OFF; cause_d = CAUSE_TAMPER; pen_enter = 1'b1;
        end else if (reprog_req) begin
          if (req_hostile_mode) begin
            state_d = ST_P_OFF; cause_d = CAUSE_HOSTILE; pen_enter = 1'b1;
          end else begin
            state_d = ST_SCRUB_GO;
          end
        end
      end
      ST_SCRUB_GO: begin
        if (tamper_any) begin
          state_d = ST_P_OFF; cause_d = CAUSE_TAMPER; pen_enter = 1'b1;
        end else begin
          state_d = ST_SCRUB_WAIT;
        end
      end
      ST_SCRUB_WAIT: begin
        if (tamper_any) begin
          state_d = ST_P_OFF; cause_d = CAUSE_TAMPER; pen_enter = 1'b1;
        end else if (scrub_done && !scrub_busy) begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (tamper_any) begin
          state_d = ST_P_OFF; cause_d = CAUSE_TAMPER; pen_enter = 1'b1;
        end else if (!reprog_req) begin
          state_d = ST_IDLE;
        end
      end
      ST_P_OFF:  if (step_done)            state_d = ST_P_RST;
      ST_P_RST:  if (step_done)            state_d = ST_P_STAT;
      ST_P_STAT: if (step_done && tx_done) state_d = ST_P_KEY;
      ST_P_KEY:  if (step_done)            state_d = ST_P_PROG;
      ST_P_PROG: if (step_done)            state_d = ST_HALT;
      ST_HALT:                             state_d = ST_HALT;
      default: begin
        state_d = ST_P_OFF; cause_d = CAUSE_BADSTATE; pen_enter = 1'b1;
      end
    endcase
  end

  assign step_load = (state_d != state_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cause_q <= CAUSE_NONE;
      snap_q  <= '0;
    end else if (pen_enter) begin
      cause_q <= cause_d;
      snap_q  <= src_mask;
    end
  end

  tamper_step_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (arst_n),
    .load    (step_load),
    .expired (step_done)
  );

  tamper_status_tx #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_status (
    .clk   (clk),
    .rst_n (arst_n),
    .go    (state_q == ST_P_STAT),
    .cause (cause_q),
    .mask  (snap_q),
    .ready (status_ready),
    .valid (status_valid),
    .data  (status_data),
    .last  (status_last),
    .done  (tx_done)
  );

  // Output decode: anything outside the benign set keeps outputs disabled.
  logic benign;
  always_comb begin
    benign        = (state_q == ST_IDLE) || (state_q == ST_SCRUB_GO) ||
                    (state_q == ST_SCRUB_WAIT) || (state_q == ST_ACK);
    out_disable   = !benign;
    reg_reset     = (state_q == ST_P_RST);
    key_erase_n   = !(state_q == ST_P_KEY);
    cfg_cmd_valid = (state_q == ST_P_PROG);
    scrub_start   = (state_q == ST_SCRUB_GO);
    reprog_ack    = (state_q == ST_ACK) || ((state_q == ST_HALT) && reprog_req);
  end

  assert_reset_under_disable_R2: assert property (@(posedge clk) disable iff (!arst_n)
    reg_reset |-> out_disable);

  assert_erase_after_status_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !key_erase_n |-> (tx_done && out_disable));

  assert_cmd_after_erase_R6: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cfg_cmd_valid) |-> $past(!key_erase_n));

  assert_ack_after_scrub_R7: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(reprog_ack) && !out_disable) |-> $past(scrub_done && !scrub_busy));

  assert_no_ack_mid_penalty_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (reprog_ack && out_disable) |-> (key_erase_n && !cfg_cmd_valid && !reg_reset));

  assert_disable_sticky_R10: assert property (@(posedge clk) disable iff (!arst_n)
    out_disable |=> out_disable);

endmodule

// File: tb/tamper_response_seq_bench.sv
module tamper_response_seq_bench;

  localparam int NUM_SRC  = 4;
  localparam int DATA_W   = 8;
  localparam int HOLD_CYC = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_SRC-1:0] tamper_in;
  logic               req_hostile_mode;
  logic               reprog_req;
  logic               reprog_ack;
  logic               scrub_start;
  logic               scrub_busy;
  logic               scrub_done;
  logic               out_disable;
  logic               reg_reset;
  logic               status_valid;
  logic               status_ready;
  logic [DATA_W-1:0]  status_data;
  logic               status_last;
  logic               key_erase_n;
  logic               cfg_cmd_valid;

  always #4ns clk = ~clk;

  tamper_response_seq #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC))
  u_tamper_response_seq (
    .clk(clk), .rst_n(rst_n), .tamper_in(tamper_in),
    .req_hostile_mode(req_hostile_mode), .reprog_req(reprog_req),
    .reprog_ack(reprog_ack), .scrub_start(scrub_start),
    .scrub_busy(scrub_busy), .scrub_done(scrub_done),
    .out_disable(out_disable), .reg_reset(reg_reset),
    .status_valid(status_valid), .status_ready(status_ready),
    .status_data(status_data), .status_last(status_last),
    .key_erase_n(key_erase_n), .cfg_cmd_valid(cfg_cmd_valid)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // Monitor state
  int cyc = 0;
  int off_first, rst_first, rst_last, key_first, key_last, prog_first, prog_last;
  int stat_first, stat_acc_last, ack_first, scrub_cnt, key_cycles, nw, unstable;
  bit last_ok, stall_en, prev_stalled;
  int stall_left;
  logic [DATA_W-1:0] words [2];
  logic [DATA_W-1:0] prev_data;

  task automatic clr_mon();
    off_first = -1; rst_first = -1; rst_last = -1; key_first = -1; key_last = -1;
    prog_first = -1; prog_last = -1; stat_first = -1; stat_acc_last = -1;
    ack_first = -1; scrub_cnt = 0; key_cycles = 0; nw = 0; unstable = 0;
    last_ok = 1'b0; prev_stalled = 1'b0; stall_left = stall_en ? 6 : 0;
    words[0] = '0; words[1] = '0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (out_disable && off_first < 0) off_first = cyc;
    if (reg_reset) begin if (rst_first < 0) rst_first = cyc; rst_last = cyc; end
    if (!key_erase_n) begin if (key_first < 0) key_first = cyc; key_last = cyc; key_cycles++; end
    if (cfg_cmd_valid) begin if (prog_first < 0) prog_first = cyc; prog_last = cyc; end
    if (reprog_ack && ack_first < 0) ack_first = cyc;
    if (scrub_start) scrub_cnt++;
    if (prev_stalled && (!status_valid || status_data != prev_data)) unstable++;
    if (status_valid && stall_left > 0) begin
      status_ready = 1'b0;
      stall_left--;
    end else begin
      status_ready = 1'b1;
    end
    if (status_valid) begin
      if (stat_first < 0) stat_first = cyc;
      if (status_ready) begin
        if (nw < 2) words[nw] = status_data;
        if (nw == 1 && status_last) last_ok = 1'b1;
        nw++;
        stat_acc_last = cyc;
      end
    end
    prev_stalled = status_valid && !status_ready;
    prev_data    = status_data;
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input bit cond);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=0 expected=1", req);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk_eq({req, " out_disable"}, int'(out_disable), 0);
    chk_eq({req, " reg_reset"}, int'(reg_reset), 0);
    chk_eq({req, " key_erase_n"}, int'(key_erase_n), 1);
    chk_eq({req, " cfg_cmd_valid"}, int'(cfg_cmd_valid), 0);
    chk_eq({req, " reprog_ack"}, int'(reprog_ack), 0);
    chk_eq({req, " scrub_start"}, int'(scrub_start), 0);
    chk_eq({req, " status_valid"}, int'(status_valid), 0);
  endtask

  task automatic do_reset();
    tamper_in = '0; req_hostile_mode = 0; reprog_req = 0;
    scrub_busy = 0; scrub_done = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    idle_outputs("R1 in reset");
    rst_n = 1;
    repeat (4) @(negedge clk);
    clr_mon();
  endtask

  task automatic wait_seq_end();
    int n = 0;
    while (!(prog_last >= 0 && !cfg_cmd_valid) && n < 600) begin
      @(negedge clk);
      n++;
    end
    chk_true("R3 penalty sequence completes", prog_last >= 0 && !cfg_cmd_valid);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_penalty(input string tag, input int exp_cause, input int exp_mask);
    chk_true({tag, " R2 disable first"}, off_first >= 0 && off_first < rst_first);
    chk_eq({tag, " R3 disable-alone cycles"}, rst_first - off_first, HOLD_CYC);
    chk_eq({tag, " R3 reg_reset cycles"}, rst_last - rst_first + 1, HOLD_CYC);
    chk_true({tag, " R4 record after reg_reset"}, stat_first > rst_last);
    chk_eq({tag, " R4 word count"}, nw, 2);
    chk_eq({tag, " R4 cause word"}, int'(words[0]), exp_cause);
    chk_eq({tag, " R4 source word"}, int'(words[1]), exp_mask);
    chk_true({tag, " R4 last flag"}, last_ok);
    chk_eq({tag, " R4 data stable under stall"}, unstable, 0);
    chk_true({tag, " R5 erase after record"}, key_first > stat_acc_last);
    chk_eq({tag, " R3 erase cycles"}, key_last - key_first + 1, HOLD_CYC);
    chk_eq({tag, " R6 command right after erase"}, prog_first, key_last + 1);
    chk_eq({tag, " R3 command cycles"}, prog_last - prog_first + 1, HOLD_CYC);
    chk_eq({tag, " R10 disable held"}, int'(out_disable), 1);
  endtask

  // {mask[3:0], hostile, req, stall, cause[1:0]}
  localparam logic [8:0] VEC [4] = '{
    {4'b0001, 1'b0, 1'b0, 1'b0, 2'b01},
    {4'b1000, 1'b0, 1'b0, 1'b1, 2'b01},
    {4'b0000, 1'b1, 1'b1, 1'b0, 2'b10},
    {4'b0110, 1'b1, 1'b0, 1'b1, 2'b01}
  };

  initial begin
    status_ready = 1'b1;
    stall_en = 1'b0;
    clr_mon();
    do_reset();
    idle_outputs("R1 after release");

    for (int i = 0; i < 4; i++) begin
      stall_en = VEC[i][2];
      do_reset();
      @(negedge clk);
      req_hostile_mode = VEC[i][4];
      reprog_req       = VEC[i][3];
      tamper_in        = VEC[i][8:5];
      wait_seq_end();
      chk_penalty($sformatf("vec%0d", i), int'(VEC[i][1:0]), int'(VEC[i][8:5]));
      if (VEC[i][3]) begin
        chk_eq("R8 no scrub in hostile mode", scrub_cnt, 0);
        chk_true("R8 ack only after command step", ack_first > prog_last);
        chk_eq("R8 ack follows request at end", int'(reprog_ack), 1);
      end else begin
        chk_eq("R2 no ack without request", ack_first, -1);
      end
    end

    // R10: inputs released after the end; nothing re-arms
    tamper_in = '0; reprog_req = 0; req_hostile_mode = 0;
    repeat (20) @(negedge clk);
    chk_eq("R10 disable stays", int'(out_disable), 1);
    chk_eq("R10 no second erase", key_cycles, HOLD_CYC);
    chk_eq("R10 no reg_reset", int'(reg_reset), 0);
    chk_eq("R10 no command", int'(cfg_cmd_valid), 0);
    chk_eq("R10 no status", int'(status_valid), 0);
    do_reset();
    idle_outputs("R10 cleared by reset");

    // R7: benign request with scrub handshake
    stall_en = 1'b0;
    do_reset();
    @(negedge clk);
    reprog_req = 1;
    for (int n = 0; n < 20 && scrub_cnt == 0; n++) @(negedge clk);
    chk_eq("R7 one scrub pulse", scrub_cnt, 1);
    scrub_busy = 1; scrub_done = 1;
    repeat (3) @(negedge clk);
    chk_eq("R7 no ack while busy", int'(reprog_ack), 0);
    scrub_busy = 0;
    @(negedge clk);
    chk_eq("R7 ack after done", int'(reprog_ack), 1);
    scrub_done = 0;
    repeat (3) @(negedge clk);
    chk_eq("R7 ack held with request", int'(reprog_ack), 1);
    chk_eq("R5 no erase on benign path", key_cycles, 0);
    chk_eq("R5 outputs stay enabled", int'(out_disable), 0);
    reprog_req = 0;
    @(negedge clk);
    chk_eq("R7 ack drops", int'(reprog_ack), 0);
    reprog_req = 1;
    for (int n = 0; n < 20 && scrub_cnt < 2; n++) @(negedge clk);
    chk_eq("R7 second request served", scrub_cnt, 2);
    scrub_done = 1;
    @(negedge clk);
    scrub_done = 0;
    chk_eq("R7 second ack", int'(reprog_ack), 1);
    reprog_req = 0;
    repeat (2) @(negedge clk);

    // R9: tamper while scrub outstanding
    do_reset();
    @(negedge clk);
    reprog_req = 1;
    for (int n = 0; n < 20 && scrub_cnt == 0; n++) @(negedge clk);
    repeat (3) @(negedge clk);
    tamper_in = 4'b0010;
    wait_seq_end();
    chk_penalty("R9 preempt", 1, 2);
    chk_true("R9 no ack before end", ack_first > prog_last);
    chk_eq("R9 ack at end", int'(reprog_ack), 1);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #1200us;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule